// File: doc/BRIEF.md
# Fixed Off-Time Winding Current Chopper

This controller drives one H-bridge winding and regulates its current by chopping. While it drives, the bridge conducts in the commanded direction until an external, already synchronized comparator reports that the current has reached its limit. The controller then starts a decay phase that lasts a fixed number of clock cycles. When that phase ends, driving resumes and the next chopping period begins. The current sensing and the reference scaling sit outside the block.

A single 3-bit setting index selects both the decay style and the off-time, and the block samples it only when a decay phase starts. Indices 1 to 3 select mixed decay: the first 30% of the off-time reverses the bridge (fast decay) and the remainder recirculates through the low sides (slow decay). Indices 4 to 6 select plain slow decay. Within each group the index picks the short, medium or long off-time, and all three lengths are parameters counted in clock cycles. Index 0, which stands for a ripple-regulated mode without a fixed off-time, is not supported, and neither is the unused code 7. Both hold the bridge off.

A near-zero-current flag ends the reversed drive early, so the winding current does not build up in the wrong direction. A one-cycle all-off gap separates every change of the four gate outputs. States: IDLE, DRIVE, FAST, COAST (bridge off during the rest of the fast share), SLOW and HOLD. Transitions: IDLE→DRIVE|HOLD on enable; DRIVE→FAST|SLOW on trip; DRIVE→HOLD on unsupported index; HOLD→DRIVE on supported index; FAST→COAST on near-zero; FAST|COAST→SLOW at the end of the fast share; FAST|COAST|SLOW→DRIVE when the off-time expires; any→IDLE when enable drops.

Top module: `chop_ctrl`

## Requirements
- R1: In DRIVE the gate pattern {ah,al,bh,bl} is 1001 when dir=1 and 0110 when dir=0, and the block stays in DRIVE until trip is seen.
- R2: A trip seen in DRIVE starts a decay phase that lasts exactly L cycles, after which the state is DRIVE. Indices 1 and 4 give L=OFF_A_CYC, indices 2 and 5 give OFF_B_CYC, and indices 3 and 6 give OFF_C_CYC.
- R3: FAST drives the reversed diagonal (0110 for a drive direction of 1, 1001 for 0). A near_zero seen in FAST moves to COAST (gates 0000) for the rest of the fast share.
- R4: SLOW drives pattern 0101, with both low sides on and both high sides off.
- R5: For indices 1 to 3 the first floor(L*FAST_PCT/100) decay cycles are fast (FAST or COAST) and the rest are SLOW. For indices 4 to 6 every decay cycle is SLOW.
- R6: An index of 0 or 7 seen in IDLE or DRIVE leads to HOLD with gates 0000, and a supported index in HOLD returns the block to DRIVE.
- R7: The setting index and the direction used by the decay are sampled only at the start of the decay. Changes to either during the decay do not alter its length, its split or its fast pattern.
- R8: A high side and the low side of the same half-bridge are never on together, and the gates never change from one nonzero pattern to another without an all-off cycle in between.
- R9: While reset is asserted, and on the cycle after en is low, the gates are 0000 and the state is IDLE. The state is DRIVE on the first cycle after en returns (for a supported index).
- R10: trip is ignored during decay. A trip still high when the off-time ends gives exactly one DRIVE cycle and then a new decay.
- R11: state_o encodes IDLE=0, DRIVE=1, FAST=2, COAST=3, SLOW=4 and HOLD=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables the bridge. When low, gates are off and the state is IDLE |
| dir | input | 1 | Commanded drive direction |
| trip | input | 1 | Synchronized current-limit comparator output |
| near_zero | input | 1 | Winding current is close to zero |
| setting | input | 3 | Decay/off-time index, 0..7 |
| gate_ah | output | 1 | High side, half-bridge A |
| gate_al | output | 1 | Low side, half-bridge A |
| gate_bh | output | 1 | High side, half-bridge B |
| gate_bl | output | 1 | Low side, half-bridge B |
| state_o | output | 3 | Current controller state (R11 encoding) |

## Verification
The bench goes after off-by-one errors in the off-time and in the fast share. A wrong counter compare shows up as a decay of L±1 cycles or a fast share of 2 or 4 cycles instead of 3. It raises near_zero in the middle of the fast share: a design that ignores the flag keeps the reversed drive on, and one that ends the fast share at the flag enters SLOW too early. It changes the index and dir in the middle of a decay, which catches a design that follows the live inputs with a changed length or pattern. It also holds trip high across the end of a decay, to catch designs that skip the single drive cycle or react to trip during decay. A per-cycle comparison of the gate outputs catches a missing all-off gap between patterns.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DRIVE = 3'd1,
        ST_FAST  = 3'd2,
        ST_COAST = 3'd3,
        ST_SLOW  = 3'd4,
        ST_HOLD  = 3'd5
    } chop_state_e;

    // Gate bit order {ah, al, bh, bl}
    localparam logic [3:0] GATES_OFF  = 4'b0000;
    localparam logic [3:0] GATES_FWD  = 4'b1001;
    localparam logic [3:0] GATES_REV  = 4'b0110;
    localparam logic [3:0] GATES_LOWS = 4'b0101;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/chop_setting_decode.sv
module chop_setting_decode #(
    parameter int OFF_A_CYC = 875,
    parameter int OFF_B_CYC = 2000,
    parameter int OFF_C_CYC = 4000,
    parameter int FAST_PCT  = 30,
    parameter int CW        = 12
) (
    input  logic [2:0]    setting,
    output logic          unsupported,
    output logic [CW-1:0] off_len,
    output logic [CW-1:0] fast_len
);
    localparam int NSLOT = 3;
    localparam int LENS [NSLOT] = '{OFF_A_CYC, OFF_B_CYC, OFF_C_CYC};

    logic [CW-1:0] len_tab  [NSLOT];
    logic [CW-1:0] fast_tab [NSLOT];
    logic [1:0]    slot;
    logic          mixed;

    for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
        assign len_tab[gi]  = CW'(LENS[gi]);
        assign fast_tab[gi] = CW'((LENS[gi] * FAST_PCT) / 100);
    end

    always_comb begin
        unique case (setting)
            3'd1, 3'd4: slot = 2'd0;
            3'd2, 3'd5: slot = 2'd1;
            3'd3, 3'd6: slot = 2'd2;
            default:    slot = 2'd0;
        endcase
        unsupported = (setting == 3'd0) || (setting == 3'd7);
        mixed       = (setting >= 3'd1) && (setting <= 3'd3);
        off_len     = len_tab[slot];
        fast_len    = mixed ? fast_tab[slot] : '0;
    end

endmodule

// File: rtl/chop_phase_fsm.sv
module chop_phase_fsm
    import chop_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          dir,
    input  logic          trip,
    input  logic          near_zero,
    input  logic          unsupported,
    input  logic [CW-1:0] off_len,
    input  logic [CW-1:0] fast_len,
    output chop_state_e   state_q,
    output logic          dec_dir_q
);
    chop_state_e   state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] off_q, fast_q;
    logic          start_decay;
    logic          last_cyc, fast_end;
    logic          decaying;

    assign decaying    = (state_q == ST_FAST) || (state_q == ST_COAST) || (state_q == ST_SLOW);
    assign last_cyc    = (cnt_q == off_q - CW'(1));
    assign fast_end    = (fast_q != '0) && (cnt_q == fast_q - CW'(1));
    assign start_decay = (state_q == ST_DRIVE) && !unsupported && trip;

    always_comb begin
        state_d = state_q;
        cnt_d   = decaying ? cnt_q + CW'(1) : '0;
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = unsupported ? ST_HOLD : ST_DRIVE;
                ST_HOLD:  if (!unsupported) state_d = ST_DRIVE;
                ST_DRIVE: begin
                    if (unsupported)  state_d = ST_HOLD;
                    else if (trip)    state_d = (fast_len != '0) ? ST_FAST : ST_SLOW;
                end
                ST_FAST: begin
                    if (last_cyc)       state_d = ST_DRIVE;
                    else if (fast_end)  state_d = ST_SLOW;
                    else if (near_zero) state_d = ST_COAST;
                end
                ST_COAST: begin
                    if (last_cyc)      state_d = ST_DRIVE;
                    else if (fast_end) state_d = ST_SLOW;
                end
                ST_SLOW:  if (last_cyc) state_d = ST_DRIVE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            off_q     <= '0;
            fast_q    <= '0;
            dec_dir_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (en && !start_decay) ? cnt_d : '0;
            if (start_decay && en) begin
                off_q     <= off_len;
                fast_q    <= fast_len;
                dec_dir_q <= dir;
            end
        end
    end

    // R2: the counter never runs past the latched off-time
    p_cnt_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        decaying |-> (cnt_q < off_q));

    // R10: trip cannot cut a decay short
    p_trip_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (decaying && en && !last_cyc) |=> (state_q == ST_FAST || state_q == ST_COAST || state_q == ST_SLOW));

    // R9: enable low sends the machine to IDLE
    p_idle_on_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == ST_IDLE));

    // R3: COAST is only reached from the fast share
    p_coast_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_COAST) |-> ($past(state_q) == ST_FAST));

endmodule

// File: rtl/chop_gate_stage.sv
module chop_gate_stage
    import chop_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        dir,
    input  logic        dec_dir,
    input  chop_state_e state,
    output logic [3:0]  gates_q
);
    logic [3:0] want;
    logic [3:0] gates_d;

    always_comb begin
        unique case (state)
            ST_DRIVE: want = dir ? GATES_FWD : GATES_REV;
            ST_FAST:  want = dec_dir ? GATES_REV : GATES_FWD;
            ST_SLOW:  want = GATES_LOWS;
            default:  want = GATES_OFF;
        endcase
        if (!en)                  gates_d = GATES_OFF;
        else if (gates_q == want) gates_d = gates_q;
        else if (gates_q == GATES_OFF) gates_d = want;
        else                      gates_d = GATES_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gates_q <= GATES_OFF;
        else        gates_q <= gates_d;
    end

    // R8: no shoot-through on either half-bridge
    p_no_shoot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(gates_q[3] && gates_q[2]) && !(gates_q[1] && gates_q[0]));

    // R8: every pattern change passes through all-off
    p_dead_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((gates_q != $past(gates_q)) && ($past(gates_q) != 4'b0000)) |-> (gates_q == 4'b0000));

    // R9: gates off on the cycle after enable is low
    p_gates_off_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (gates_q == 4'b0000));

    // R6: HOLD keeps the bridge off
    p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> (gates_q == 4'b0000));

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int OFF_A_CYC = 875,
    parameter int OFF_B_CYC = 2000,
    parameter int OFF_C_CYC = 4000,
    parameter int FAST_PCT  = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       dir,
    input  logic       trip,
    input  logic       near_zero,
    input  logic [2:0] setting,
    output logic       gate_ah,
    output logic       gate_al,
    output logic       gate_bh,
    output logic       gate_bl,
    output logic [2:0] state_o
);
    localparam int MAX_OFF = max3(OFF_A_CYC, OFF_B_CYC, OFF_C_CYC);
    localparam int CW      = $clog2(MAX_OFF + 1);

    logic          unsupported;
    logic [CW-1:0] off_len, fast_len;
    chop_state_e   state_q;
    logic          dec_dir_q;
    logic [3:0]    gates_q;

    chop_setting_decode #(
        .OFF_A_CYC(OFF_A_CYC), .OFF_B_CYC(OFF_B_CYC), .OFF_C_CYC(OFF_C_CYC),
        .FAST_PCT(FAST_PCT), .CW(CW)
    ) u_decode (
        .setting(setting), .unsupported(unsupported),
        .off_len(off_len), .fast_len(fast_len)
    );

    chop_phase_fsm #(.CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .dir(dir), .trip(trip),
        .near_zero(near_zero), .unsupported(unsupported),
        .off_len(off_len), .fast_len(fast_len),
        .state_q(state_q), .dec_dir_q(dec_dir_q)
    );

    chop_gate_stage u_gates (
        .clk(clk), .rst_n(rst_n), .en(en), .dir(dir), .dec_dir(dec_dir_q),
        .state(state_q), .gates_q(gates_q)
    );

    assign {gate_ah, gate_al, gate_bh, gate_bl} = gates_q;
    assign state_o = state_q;

endmodule

// File: tb/chop_ctrl_tb_top.sv
module chop_ctrl_tb_top;
    localparam int LA = 10, LB = 20, LC = 40, PCT = 30;
    localparam int S_IDLE = 0, S_DRIVE = 1, S_FAST = 2, S_COAST = 3, S_SLOW = 4, S_HOLD = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, dir = 1'b1, trip = 1'b0, near_zero = 1'b0;
    logic [2:0] setting = 3'd1;
    logic gate_ah, gate_al, gate_bh, gate_bl;
    logic [2:0] state_o;

    int n_checks = 0, n_fails = 0, cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    chop_ctrl #(.OFF_A_CYC(LA), .OFF_B_CYC(LB), .OFF_C_CYC(LC), .FAST_PCT(PCT)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .dir(dir), .trip(trip),
        .near_zero(near_zero), .setting(setting),
        .gate_ah(gate_ah), .gate_al(gate_al), .gate_bh(gate_bh), .gate_bl(gate_bl),
        .state_o(state_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_st = S_IDLE, m_cnt = 0, m_len = 0, m_fast = 0;
    logic [3:0] m_g = 4'b0;
    logic m_dd = 1'b0;
    logic [3:0] m_want;

    function automatic int len_of(input int s);
        if (s == 1 || s == 4) return LA;
        if (s == 2 || s == 5) return LB;
        return LC;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = S_IDLE; m_cnt = 0; m_len = 0; m_fast = 0; m_g = 4'b0; m_dd = 1'b0;
        end else if (!en) begin
            m_st = S_IDLE; m_g = 4'b0; m_cnt = 0;
        end else begin
            if (m_st == S_DRIVE)     m_want = dir ? 4'b1001 : 4'b0110;
            else if (m_st == S_FAST) m_want = m_dd ? 4'b0110 : 4'b1001;
            else if (m_st == S_SLOW) m_want = 4'b0101;
            else                     m_want = 4'b0000;
            if (m_g != m_want) m_g = (m_g == 4'b0) ? m_want : 4'b0;
            if (m_st == S_IDLE) begin
                m_st = (setting == 0 || setting == 7) ? S_HOLD : S_DRIVE;
            end else if (m_st == S_HOLD) begin
                if (setting != 0 && setting != 7) m_st = S_DRIVE;
            end else if (m_st == S_DRIVE) begin
                if (setting == 0 || setting == 7) m_st = S_HOLD;
                else if (trip) begin
                    m_len  = len_of(int'(setting));
                    m_fast = (setting <= 3) ? (m_len * PCT) / 100 : 0;
                    m_dd   = dir;
                    m_cnt  = 0;
                    m_st   = (m_fast > 0) ? S_FAST : S_SLOW;
                end
            end else begin
                if (m_cnt == m_len - 1) m_st = S_DRIVE;
                else if ((m_st == S_FAST || m_st == S_COAST) && m_cnt == m_fast - 1) m_st = S_SLOW;
                else if (m_st == S_FAST && near_zero) m_st = S_COAST;
                m_cnt++;
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    logic [3:0] prev_g = 4'b0;
    always @(negedge clk) begin
        logic [3:0] g;
        string tg;
        g = {gate_ah, gate_al, gate_bh, gate_bl};
        if (rst_n && !done) begin
            case (m_st)
                S_DRIVE: tg = "R1 drive";
                S_FAST, S_COAST: tg = "R3 fast/coast";
                S_SLOW:  tg = "R4 slow";
                S_HOLD:  tg = "R6 hold";
                default: tg = "R9 idle";
            endcase
            check({tg, " gates"}, int'(g), int'(m_g));
            check("R11 state code", int'(state_o), m_st);
            check("R8 shoot-through", int'((g[3] & g[2]) | (g[1] & g[0])), 0);
            if (g != prev_g && prev_g != 4'b0)
                check("R8 dead gap", int'(g), 0);
        end
        prev_g = g;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 50000);
            finish_up();
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // pulse trip for one cycle from DRIVE and tally the decay states
    task automatic run_decay(input int nz_at, output int nf, output int nc, output int ns);
        int i;
        nf = 0; nc = 0; ns = 0; i = 0;
        trip = 1'b1; step(1); trip = 1'b0;
        while (state_o != 3'(S_DRIVE) && i < 500) begin
            if (state_o == 3'(S_FAST))  nf++;
            if (state_o == 3'(S_COAST)) nc++;
            if (state_o == 3'(S_SLOW))  ns++;
            near_zero = (i == nz_at);
            i++;
            step(1);
        end
        near_zero = 1'b0;
    endtask

    initial begin
        int nf, nc, ns, nd;
        step(3);
        check("R9 reset gates", int'({gate_ah, gate_al, gate_bh, gate_bl}), 0);
        check("R9 reset state", int'(state_o), S_IDLE);
        rst_n = 1'b1;
        step(1);
        en = 1'b1; setting = 3'd1; dir = 1'b1;
        step(1);
        check("R9 drive after enable", int'(state_o), S_DRIVE);
        step(4);
        check("R1 forward pattern", int'({gate_ah, gate_al, gate_bh, gate_bl}), 'b1001);
        check("R1 stays in drive", int'(state_o), S_DRIVE);

        run_decay(-1, nf, nc, ns);
        check("R5 mixed fast share idx1", nf, 3);
        check("R5 mixed slow share idx1", ns, 7);
        check("R2 length idx1", nf + nc + ns, LA);
        step(3);

        setting = 3'd4;
        run_decay(-1, nf, nc, ns);
        check("R5 idx4 no fast", nf + nc, 0);
        check("R4 idx4 all slow", ns, LA);
        step(3);

        setting = 3'd2;
        run_decay(-1, nf, nc, ns);
        check("R2 length idx2", nf + nc + ns, LB);
        check("R5 fast share idx2", nf, 6);
        step(3);

        setting = 3'd6;
        run_decay(-1, nf, nc, ns);
        check("R2 length idx6", nf + nc + ns, LC);
        step(3);

        setting = 3'd3;
        run_decay(2, nf, nc, ns);
        check("R3 fast before near-zero", nf, 3);
        check("R3 coast rest of fast share", nc, 9);
        check("R5 slow after coast", ns, 28);
        step(3);

        // R7: change index and direction mid-decay
        setting = 3'd1; dir = 1'b1;
        trip = 1'b1; step(1); trip = 1'b0;
        setting = 3'd6; dir = 1'b0;
        nd = 1;
        while (state_o != 3'(S_DRIVE) && nd < 500) begin nd++; step(1); end
        check("R7 latched length", nd - 1, LA);
        setting = 3'd1;
        step(4);
        check("R1 reverse pattern", int'({gate_ah, gate_al, gate_bh, gate_bl}), 'b0110);
        run_decay(-1, nf, nc, ns);
        check("R3 dir0 fast share", nf, 3);
        step(3);
        dir = 1'b1;
        step(3);

        // R10: hold trip across the end of the off-time
        trip = 1'b1;
        step(1);
        nd = 0;
        while (state_o != 3'(S_DRIVE) && nd < 500) begin nd++; step(1); end
        nd = 0;
        while (state_o == 3'(S_DRIVE) && nd < 500) begin nd++; step(1); end
        check("R10 single drive cycle", nd, 1);
        trip = 1'b0;
        nd = 0;
        while (state_o != 3'(S_DRIVE) && nd < 500) begin nd++; step(1); end
        step(3);

        // R6: unsupported index
        setting = 3'd0;
        step(3);
        check("R6 hold state", int'(state_o), S_HOLD);
        check("R6 hold gates", int'({gate_ah, gate_al, gate_bh, gate_bl}), 0);
        trip = 1'b1; step(3); trip = 1'b0;
        check("R6 trip ignored in hold", int'(state_o), S_HOLD);
        setting = 3'd7; step(2);
        check("R6 code 7 held", int'(state_o), S_HOLD);
        setting = 3'd5; step(1);
        check("R6 leave hold", int'(state_o), S_DRIVE);
        step(3);

        // R9: enable drop mid-decay
        setting = 3'd3;
        trip = 1'b1; step(1); trip = 1'b0;
        step(2);
        en = 1'b0; step(1);
        check("R9 idle on disable", int'(state_o), S_IDLE);
        check("R9 gates off on disable", int'({gate_ah, gate_al, gate_bh, gate_bl}), 0);
        en = 1'b1; step(1);
        check("R9 resume drive", int'(state_o), S_DRIVE);
        step(5);
        finish_up();
    end

endmodule